// File: doc/BRIEF.md
# Interrupt Status and Enable Register with Per-Bit Reset Domains

This block is the host-visible interrupt status register of a network controller. It latches three events coming from elsewhere in the controller: the controller leaving sleep, the transmitter giving up on a frame after deferring too long, and a wake-up packet arriving while wake-up mode is on. Each latched flag has its own enable bit. The block combines the enabled flags into one active-low interrupt line. A separate control bit tells the wake-up packet matcher whether to accept any destination address class. That bit is stored here and driven out to the matcher.

The host reads the whole register at any time through `rd_data`, and reading has no side effects. A write strobe loads the enable and control bits from the written word. The same write clears any flag whose bit is written as 1. The bits differ in how they respond to the three reset sources. A hard reset clears everything. A soft reset clears only the wake-up flag, the wake-up enable and the address-accept bit. The stop command clears only the wake-up flag. The sleep-exit and deferral pairs survive soft reset, because entering sleep issues a soft reset that also drops the controller-wide interrupt enable. For the same reason only the wake-up flag is gated by that global enable.

Register layout (unused upper bits read 0): bit 0 sleep-exit flag, bit 1 deferral flag, bit 2 wake-up flag, bit 3 sleep-exit enable, bit 4 deferral enable, bit 5 wake-up enable, bit 6 address-accept control.

Top module: `irq_stat_reg`

## Requirements
- R1: While `hard_rst_n` is low, and right after it, `rd_data` reads all zeros, `irq_n` is 1 and `bcast_accept` is 0.
- R2: A one-cycle pulse on `sleep_exit_evt` or `defer_evt` sets flag bit 0 or bit 1, seen on `rd_data` after that clock edge. `wake_pkt_evt` sets bit 2 only when `wake_mode` is 1 in the same cycle, and otherwise has no effect.
- R3: A write with bit 0, 1 or 2 of `wr_data` at 1 clears that flag after the edge. A flag whose bit is written as 0 keeps its value.
- R4: If a set event and a write-one-to-clear hit the same flag in the same cycle, the flag ends up set.
- R5: `soft_rst` clears bit 2 (wake-up flag), bit 5 (wake-up enable) and bit 6 (address accept) after the edge. It leaves bits 0, 1, 3 and 4 unchanged. It wins over a same-cycle write or set of those cleared bits.
- R6: `stop_cmd` clears bit 2 after the edge, winning over a same-cycle set. It leaves every other bit unchanged.
- R7: `irq_n` is 0 exactly when (bit0 & bit3) | (bit1 & bit4) | (bit2 & bit5 & `glob_ie`) is 1. It follows `glob_ie` in the same cycle.
- R8: A write loads bits 3 to 6 from `wr_data`. Bits at positions 7 and above ignore writes and always read 0. `bcast_accept` equals bit 6.
- R9: With no write, no event and no reset input active, `rd_data` stays the same from cycle to cycle, however often it is read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| hard_rst_n | input | 1 | Asynchronous active-low hard reset, clears every bit |
| soft_rst | input | 1 | Synchronous soft reset, clears the wake-up group |
| stop_cmd | input | 1 | Synchronous stop command, clears the wake-up flag |
| glob_ie | input | 1 | Controller-wide interrupt enable, gates only the wake-up flag |
| sleep_exit_evt | input | 1 | Pulse: controller left sleep |
| defer_evt | input | 1 | Pulse: transmit excessive deferral |
| wake_mode | input | 1 | Wake-up packet mode active |
| wake_pkt_evt | input | 1 | Pulse: matching wake-up packet received |
| wr_en | input | 1 | Host write strobe |
| wr_data | input | DATA_W | Host write data |
| rd_data | output | DATA_W | Register read value |
| bcast_accept | output | 1 | Address-accept control to the packet matcher |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The bench builds the block with `DATA_W` set to 16, not the default 8. This gives nine unused upper bits, and the bench writes ones into them to show that they are ignored and read back as zero. It drives each reset source alone and together with sets and writes in the same cycle, so every ordering of the priorities shows up. A behavioural reference model is compared against both outputs on every clock.

// File: rtl/irq_stat_pkg.sv
package irq_stat_pkg;

  localparam int NUM_FLAGS  = 3;
  localparam int IDX_SLEEP  = 0;
  localparam int IDX_DEFER  = 1;
  localparam int IDX_WAKE   = 2;

  localparam int FLAG_LSB   = 0;
  localparam int EN_LSB     = FLAG_LSB + NUM_FLAGS;
  localparam int ACCEPT_BIT = EN_LSB + NUM_FLAGS;
  localparam int USED_BITS  = ACCEPT_BIT + 1;

  // reset-domain membership of each flag
  function automatic bit flag_soft_clears(int idx);
    return idx == IDX_WAKE;
  endfunction

  function automatic bit flag_stop_clears(int idx);
    return idx == IDX_WAKE;
  endfunction

  function automatic bit flag_needs_gie(int idx);
    return idx == IDX_WAKE;
  endfunction

  function automatic bit enable_soft_clears(int idx);
    return idx == IDX_WAKE;
  endfunction

  function automatic logic [NUM_FLAGS-1:0] gie_gate_mask();
    logic [NUM_FLAGS-1:0] m;
    for (int i = 0; i < NUM_FLAGS; i++) m[i] = flag_needs_gie(i);
    return m;
  endfunction

  // request of one flag: flag and enable, optionally qualified by gie
  function automatic logic flag_request(logic f, logic e, logic gated, logic gie);
    return f & e & (gated ? gie : 1'b1);
  endfunction

endpackage

// File: rtl/isr_flag_cell.sv
module isr_flag_cell #(
  parameter bit SOFT_CLR = 1'b0,
  parameter bit STOP_CLR = 1'b0
) (
  input  logic clk,
  input  logic hard_rst_n,
  input  logic set_i,
  input  logic w1c_i,
  input  logic soft_i,
  input  logic stop_i,
  output logic q_o
);

  logic dom_clr;
  assign dom_clr = (SOFT_CLR & soft_i) | (STOP_CLR & stop_i);

  // priority: reset domain, then set, then host clear
  always_ff @(posedge clk or negedge hard_rst_n) begin
    if (!hard_rst_n)  q_o <= 1'b0;
    else if (dom_clr) q_o <= 1'b0;
    else if (set_i)   q_o <= 1'b1;
    else if (w1c_i)   q_o <= 1'b0;
  end

  p_set_r2: assert property (@(posedge clk) disable iff (!hard_rst_n)
    (set_i && !dom_clr) |=> q_o);

  p_w1c_r3: assert property (@(posedge clk) disable iff (!hard_rst_n)
    (w1c_i && !set_i && !dom_clr) |=> !q_o);

  p_hold_r3: assert property (@(posedge clk) disable iff (!hard_rst_n)
    (!w1c_i && !set_i && !dom_clr) |=> $stable(q_o));

  p_set_wins_r4: assert property (@(posedge clk) disable iff (!hard_rst_n)
    (set_i && w1c_i && !dom_clr) |=> q_o);

  // R5 / R6: a member reset domain clears the flag
  p_dom_clr_r5: assert property (@(posedge clk) disable iff (!hard_rst_n)
    dom_clr |=> !q_o);

endmodule

// File: rtl/isr_ctrl_cell.sv
module isr_ctrl_cell #(
  parameter bit SOFT_CLR = 1'b0
) (
  input  logic clk,
  input  logic hard_rst_n,
  input  logic wr_i,
  input  logic d_i,
  input  logic soft_i,
  output logic q_o
);

  logic soft_hit;
  assign soft_hit = SOFT_CLR & soft_i;

  always_ff @(posedge clk or negedge hard_rst_n) begin
    if (!hard_rst_n)   q_o <= 1'b0;
    else if (soft_hit) q_o <= 1'b0;
    else if (wr_i)     q_o <= d_i;
  end

  p_write_r8: assert property (@(posedge clk) disable iff (!hard_rst_n)
    (wr_i && !soft_hit) |=> (q_o == $past(d_i)));

  p_keep_r5: assert property (@(posedge clk) disable iff (!hard_rst_n)
    (!wr_i && !soft_hit) |=> $stable(q_o));

  generate
    if (SOFT_CLR) begin : g_soft
      p_soft_clr_r5: assert property (@(posedge clk) disable iff (!hard_rst_n)
        soft_i |=> !q_o);
    end
  endgenerate

endmodule

// File: rtl/isr_irq_merge.sv
module isr_irq_merge
  import irq_stat_pkg::*;
#(
  parameter int NF = NUM_FLAGS,
  parameter logic [NF-1:0] GATE = '0
) (
  input  logic [NF-1:0] flags_i,
  input  logic [NF-1:0] ens_i,
  input  logic          gie_i,
  output logic [NF-1:0] req_o,
  output logic          irq_n_o
);

  for (genvar i = 0; i < NF; i++) begin : g_req
    assign req_o[i] = flag_request(flags_i[i], ens_i[i], GATE[i], gie_i);
  end

  assign irq_n_o = ~(|req_o);

endmodule

// File: rtl/irq_stat_reg.sv
module irq_stat_reg
  import irq_stat_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              hard_rst_n,
  input  logic              soft_rst,
  input  logic              stop_cmd,
  input  logic              glob_ie,
  input  logic              sleep_exit_evt,
  input  logic              defer_evt,
  input  logic              wake_mode,
  input  logic              wake_pkt_evt,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              bcast_accept,
  output logic              irq_n
);

  localparam logic [NUM_FLAGS-1:0] GATE_MASK = gie_gate_mask();

  logic [NUM_FLAGS-1:0] set_vec;
  logic [NUM_FLAGS-1:0] w1c_vec;
  logic [NUM_FLAGS-1:0] flag_q;
  logic [NUM_FLAGS-1:0] en_q;
  logic [NUM_FLAGS-1:0] req_vec;
  logic                 accept_q;

  // event wires brought out for the checks
  logic wake_set_ok;
  logic sleep_pair;
  logic defer_pair;
  logic wake_pair;
  assign wake_set_ok = wake_mode & wake_pkt_evt;
  assign sleep_pair  = flag_q[IDX_SLEEP] & en_q[IDX_SLEEP];
  assign defer_pair  = flag_q[IDX_DEFER] & en_q[IDX_DEFER];
  assign wake_pair   = flag_q[IDX_WAKE]  & en_q[IDX_WAKE];

  assign set_vec[IDX_SLEEP] = sleep_exit_evt;
  assign set_vec[IDX_DEFER] = defer_evt;
  assign set_vec[IDX_WAKE]  = wake_set_ok;

  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_bit
    assign w1c_vec[i] = wr_en & wr_data[FLAG_LSB+i];

    isr_flag_cell #(
      .SOFT_CLR (flag_soft_clears(i)),
      .STOP_CLR (flag_stop_clears(i))
    ) u_flag (
      .clk        (clk),
      .hard_rst_n (hard_rst_n),
      .set_i      (set_vec[i]),
      .w1c_i      (w1c_vec[i]),
      .soft_i     (soft_rst),
      .stop_i     (stop_cmd),
      .q_o        (flag_q[i])
    );

    isr_ctrl_cell #(
      .SOFT_CLR (enable_soft_clears(i))
    ) u_en (
      .clk        (clk),
      .hard_rst_n (hard_rst_n),
      .wr_i       (wr_en),
      .d_i        (wr_data[EN_LSB+i]),
      .soft_i     (soft_rst),
      .q_o        (en_q[i])
    );
  end

  isr_ctrl_cell #(
    .SOFT_CLR (1'b1)
  ) u_accept (
    .clk        (clk),
    .hard_rst_n (hard_rst_n),
    .wr_i       (wr_en),
    .d_i        (wr_data[ACCEPT_BIT]),
    .soft_i     (soft_rst),
    .q_o        (accept_q)
  );

  isr_irq_merge #(
    .NF   (NUM_FLAGS),
    .GATE (GATE_MASK)
  ) u_merge (
    .flags_i (flag_q),
    .ens_i   (en_q),
    .gie_i   (glob_ie),
    .req_o   (req_vec),
    .irq_n_o (irq_n)
  );

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NUM_FLAGS; i++) begin
      rd_data[FLAG_LSB+i] = flag_q[i];
      rd_data[EN_LSB+i]   = en_q[i];
    end
    rd_data[ACCEPT_BIT] = accept_q;
  end

  assign bcast_accept = accept_q;

  // ---------------- checks ----------------
  p_reset_r1: assert property (@(posedge clk) !hard_rst_n |-> (irq_n && !bcast_accept));

  p_wake_needs_mode_r2: assert property (@(posedge clk) disable iff (!hard_rst_n)
    (!wake_mode && !wr_en && !soft_rst && !stop_cmd) |=> $stable(rd_data[FLAG_LSB+IDX_WAKE]));

  p_soft_keeps_sleep_r5: assert property (@(posedge clk) disable iff (!hard_rst_n)
    (soft_rst && !wr_en && !sleep_exit_evt && !defer_evt)
      |=> ($stable(rd_data[FLAG_LSB+IDX_DEFER:FLAG_LSB]) &&
           $stable(rd_data[EN_LSB+IDX_DEFER:EN_LSB])));

  p_stop_clr_r6: assert property (@(posedge clk) disable iff (!hard_rst_n)
    stop_cmd |=> !rd_data[FLAG_LSB+IDX_WAKE]);

  p_ungated_irq_r7: assert property (@(posedge clk) disable iff (!hard_rst_n)
    (sleep_pair || defer_pair) |-> !irq_n);

  p_gated_irq_r7: assert property (@(posedge clk) disable iff (!hard_rst_n)
    (!sleep_pair && !defer_pair && !(wake_pair && glob_ie)) |-> irq_n);

  p_accept_out_r8: assert property (@(posedge clk) disable iff (!hard_rst_n)
    bcast_accept == rd_data[ACCEPT_BIT]);

  p_idle_stable_r9: assert property (@(posedge clk) disable iff (!hard_rst_n)
    (!wr_en && !soft_rst && !stop_cmd && !sleep_exit_evt && !defer_evt && !wake_set_ok)
      |=> $stable(rd_data));

  generate
    if (DATA_W > USED_BITS) begin : g_upper
      p_upper_ignored_r8: assert property (@(posedge clk) disable iff (!hard_rst_n)
        (wr_en && |wr_data[DATA_W-1:USED_BITS]) |=> (rd_data[DATA_W-1:USED_BITS] == '0));
    end
  endgenerate

endmodule

// File: tb/sim_irq_stat_reg.sv
module sim_irq_stat_reg;

  localparam int CLK_PERIOD = 10;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic hard_rst_n = 1'b0;
  logic soft_rst = 1'b0, stop_cmd = 1'b0, glob_ie = 1'b0;
  logic sleep_exit_evt = 1'b0, defer_evt = 1'b0, wake_mode = 1'b0, wake_pkt_evt = 1'b0;
  logic wr_en = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic bcast_accept, irq_n;

  int checks = 0;
  int errors = 0;

  // reference state
  bit m_sf, m_df, m_wf, m_se, m_de, m_we, m_ba;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_stat_reg #(.DATA_W(DW)) u0 (
    .clk(clk), .hard_rst_n(hard_rst_n), .soft_rst(soft_rst), .stop_cmd(stop_cmd),
    .glob_ie(glob_ie), .sleep_exit_evt(sleep_exit_evt), .defer_evt(defer_evt),
    .wake_mode(wake_mode), .wake_pkt_evt(wake_pkt_evt), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .bcast_accept(bcast_accept), .irq_n(irq_n)
  );

  function automatic logic [DW-1:0] exp_word();
    logic [DW-1:0] w = '0;
    w[0] = m_sf; w[1] = m_df; w[2] = m_wf;
    w[3] = m_se; w[4] = m_de; w[5] = m_we; w[6] = m_ba;
    return w;
  endfunction

  function automatic logic exp_irq_n();
    int hits = 0;
    if (m_sf && m_se) hits++;
    if (m_df && m_de) hits++;
    if (m_wf && m_we && glob_ie) hits++;
    return (hits == 0);
  endfunction

  task automatic model_edge();
    bit w0, w1, w2;
    if (!hard_rst_n) begin
      {m_sf, m_df, m_wf, m_se, m_de, m_we, m_ba} = '0;
      return;
    end
    w0 = wr_en && wr_data[0];
    w1 = wr_en && wr_data[1];
    w2 = wr_en && wr_data[2];
    if (sleep_exit_evt) m_sf = 1; else if (w0) m_sf = 0;
    if (defer_evt) m_df = 1; else if (w1) m_df = 0;
    if (wake_mode && wake_pkt_evt) m_wf = 1; else if (w2) m_wf = 0;
    if (soft_rst || stop_cmd) m_wf = 0;
    if (wr_en) begin
      m_se = wr_data[3]; m_de = wr_data[4]; m_we = wr_data[5]; m_ba = wr_data[6];
    end
    if (soft_rst) begin
      m_we = 0; m_ba = 0;
    end
  endtask

  task automatic compare(input string tag);
    checks++;
    if (rd_data !== exp_word()) begin
      errors++;
      $display("FAIL %s: rd_data got %h expected %h", tag, rd_data, exp_word());
    end
    checks++;
    if (irq_n !== exp_irq_n()) begin
      errors++;
      $display("FAIL %s: irq_n got %b expected %b", tag, irq_n, exp_irq_n());
    end
    checks++;
    if (bcast_accept !== m_ba) begin
      errors++;
      $display("FAIL %s: bcast_accept got %b expected %b", tag, bcast_accept, m_ba);
    end
  endtask

  // one clock: model and DUT advance, compare, drop pulses
  task automatic cyc(input string tag);
    @(posedge clk);
    model_edge();
    #1;
    compare(tag);
    sleep_exit_evt = 0; defer_evt = 0; wake_pkt_evt = 0;
    soft_rst = 0; stop_cmd = 0; wr_en = 0; wr_data = '0;
  endtask

  task automatic host_write(input logic [DW-1:0] d, input string tag);
    wr_en = 1; wr_data = d;
    cyc(tag);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog R1: run hung, got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R1: reset state
    cyc("R1"); cyc("R1");
    hard_rst_n = 1;
    cyc("R1");

    // R2: each event sets its flag; wake needs wake_mode
    sleep_exit_evt = 1; cyc("R2");
    defer_evt = 1;      cyc("R2");
    wake_pkt_evt = 1;   cyc("R2");   // ignored: mode off
    cyc("R2");
    wake_mode = 1; wake_pkt_evt = 1; cyc("R2");

    // R7: enables and glob_ie
    host_write(16'h0020, "R7");       // wake enable only
    cyc("R7");                          // gie=0 -> irq stays high
    glob_ie = 1; #1; compare("R7");     // same-cycle response
    cyc("R7");
    glob_ie = 0; #1; compare("R7");
    host_write(16'h0008, "R7");       // sleep enable only, ungated
    host_write(16'h0010, "R7");       // deferral enable only

    // R3: write-one-to-clear, zero keeps
    host_write(16'h0010, "R3");       // flag bits 0, no change
    host_write(16'h0012, "R3");       // clear deferral flag
    host_write(16'h0019, "R3");       // clear sleep flag
    host_write(16'h0038, "R3");

    // R4: set beats simultaneous clear
    sleep_exit_evt = 1; wr_en = 1; wr_data = 16'h0039; cyc("R4");
    defer_evt = 1; wr_en = 1; wr_data = 16'h003A; cyc("R4");
    wake_pkt_evt = 1; wr_en = 1; wr_data = 16'h003C; cyc("R4");

    // R8: control bits and upper bits
    host_write(16'hFFF8, "R8");
    host_write(16'hFF80, "R8");
    host_write(16'h0078, "R8");

    // R5: soft reset groups, and it beats write/set
    glob_ie = 1;
    soft_rst = 1; cyc("R5");
    host_write(16'h0078, "R5");
    wake_pkt_evt = 1; cyc("R5");
    soft_rst = 1; wake_pkt_evt = 1; wr_en = 1; wr_data = 16'h0060; cyc("R5");
    soft_rst = 1; sleep_exit_evt = 1; defer_evt = 1; cyc("R5");

    // R6: stop clears only wake flag
    host_write(16'h0078, "R6");
    wake_pkt_evt = 1; cyc("R6");
    stop_cmd = 1; cyc("R6");
    wake_pkt_evt = 1; cyc("R6");
    stop_cmd = 1; wake_pkt_evt = 1; cyc("R6");

    // R9: idle reads stay put
    wake_pkt_evt = 1; cyc("R9");
    for (int i = 0; i < 6; i++) cyc("R9");
    wake_mode = 0;
    for (int i = 0; i < 3; i++) begin
      wake_pkt_evt = 1; cyc("R9");
    end

    // R1: hard reset mid-run
    hard_rst_n = 0; #1; checks++;
    if (rd_data !== '0 || irq_n !== 1'b1) begin
      errors++;
      $display("FAIL R1: async reset got %h/%b expected 0000/1", rd_data, irq_n);
    end
    cyc("R1");
    hard_rst_n = 1;
    cyc("R1");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule